// File: doc/BRIEF.md
# Paged Parallel Host Memory Bridge

This block lets an external host CPU with an asynchronous parallel bus reach a 64 KB shared dual-port memory. The host drives a chip select, read and write strobes, a 14-bit in-page offset, two page-select bits, two byte enables and a 16-bit data bus. The bridge first passes the control strobes through a two-flop synchronizer. It then builds the full byte address from the page bits and the offset, and issues one request on a synchronous memory port. It steers the byte lanes and returns a ready handshake to the host.

Two static configuration inputs set the operating mode. `cfg_page4k` picks 16 KB or 4 KB page windows. `cfg_bus16` picks a 16-bit or an 8-bit host data path. Both paths use little-endian byte order. The memory port is a plain one-cycle request with a fixed read latency of one clock. It has no back-pressure: a request in cycle N is always accepted, and read data is valid in cycle N+1. On the host side, flow control is the ready output alone. The host holds its strobe, address and data until ready is high, and then releases the strobe.

Top module: `paged_host_bridge`

## Requirements
- R1: After reset, `host_ready` and `mem_en` are low and no memory request is made.
- R2: With `cfg_page4k`=0, the byte address is `{host_page, host_addr[13:0]}`, so each page is a 16 KB window and the four pages cover 0x0000–0xFFFF.
- R3: With `cfg_page4k`=1, page values 0, 1, 2 and 3 select 4 KB windows based at 0x0000, 0x1000, 0x8000 and 0x9000. The byte address is `{host_page[1], 2'b00, host_page[0], host_addr[11:0]}`, and `host_addr[13:12]` is ignored.
- R4: In 16-bit mode (`cfg_bus16`=1), byte address bit 0 is forced to 0. A write drives `mem_be` = `host_be` (bit 0 is the low lane [7:0], bit 1 is the high lane [15:8]) and `mem_wdata` = `host_wdata`, so only the enabled lanes of the word change.
- R5: In 16-bit mode, a read returns the whole 16-bit word at `mem_addr` = byte address [15:1] on `host_rdata`.
- R6: In 8-bit mode, a write sets `mem_be` to 2'b01 when byte address bit 0 is 0 and to 2'b10 when it is 1. `host_wdata[7:0]` appears on both lanes of `mem_wdata`, and `host_be` is ignored.
- R7: In 8-bit mode, a read places the byte selected by address bit 0 on `host_rdata[7:0]`, with `host_rdata[15:8]` = 0.
- R8: Suppose chip select and a strobe are set up half a clock before a rising edge. Ready rises at the fifth rising edge: two synchronizer edges, one detection edge and a fixed two-clock wait. Ready then stays high while the strobe is held, and falls at the third rising edge after the strobe is released.
- R9: Each access makes exactly one single-cycle memory request, with `mem_we` high for a write and low for a read.
- R10: A read or write strobe while chip select is low is ignored: no memory request is made and ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page4k | input | 1 | 1 = 4 KB page windows, 0 = 16 KB |
| cfg_bus16 | input | 1 | 1 = 16-bit host data path, 0 = 8-bit |
| host_cs | input | 1 | Host chip select, active high, asynchronous |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_page | input | 2 | Page select bits |
| host_addr | input | 14 | In-page byte offset |
| host_be | input | 2 | Byte enables (bit 0 low lane, bit 1 high lane) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data returned to the host |
| host_ready | output | 1 | Access complete, held until strobe release |
| mem_en | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 15 | Memory word address |
| mem_be | output | 2 | Memory byte-lane write enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one clock after the request |

## Verification
The address map is swept over both page sizes, all four page values, and offsets that set or clear bits 0, 12 and 13. The bit-0 offsets show whether 16-bit mode forces word alignment. The bit-12 and bit-13 offsets show whether 4 KB mode drops the upper offset bits and places windows at 0x8000 and 0x9000 instead of contiguously. Reads and writes are repeated in both bus widths. Byte enables rotate through low-only, high-only and both, so lane steering and byte selection are checked against values computed from the address. Every access also measures the ready latency on assert and on release, and a strobe without chip select confirms that nothing happens.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_LAT  = 2'd2,
    ST_DONE = 2'd3
  } hb_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hb_addr_map.sv
module hb_addr_map #(
  parameter int OFS_W = 14,
  localparam int SMALL_W = OFS_W - 2,
  localparam int AW = OFS_W + 2
) (
  input  logic             page4k,
  input  logic             bus16,
  input  logic [1:0]       page,
  input  logic [OFS_W-1:0] ofs,
  output logic [AW-1:0]    byte_addr
);
  logic [AW-1:0] raw;

  always_comb begin
    if (page4k) raw = {page[1], 2'b00, page[0], ofs[SMALL_W-1:0]};
    else        raw = {page, ofs};
    byte_addr = raw;
    if (bus16) byte_addr[0] = 1'b0;
  end
endmodule

// File: rtl/hb_lanes.sv
module hb_lanes #(
  parameter int DW = 16,
  localparam int BW = DW / 2
) (
  input  logic          bus16,
  input  logic          lane_hi,
  input  logic [1:0]    host_be,
  input  logic [DW-1:0] host_wdata,
  output logic [1:0]    mem_be,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] rd_word
);
  always_comb begin
    if (bus16) begin
      mem_be    = host_be;
      mem_wdata = host_wdata;
      rd_word   = mem_rdata;
    end else begin
      mem_be    = lane_hi ? 2'b10 : 2'b01;
      mem_wdata = {host_wdata[BW-1:0], host_wdata[BW-1:0]};
      rd_word   = {{BW{1'b0}}, lane_hi ? mem_rdata[DW-1:BW] : mem_rdata[BW-1:0]};
    end
  end
endmodule

// File: rtl/paged_host_bridge.sv
module paged_host_bridge
  import hb_pkg::*;
#(
  parameter int OFS_W = 14,
  parameter int DW = 16,
  localparam int AW = OFS_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_page4k,
  input  logic             cfg_bus16,
  input  logic             host_cs,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [1:0]       host_page,
  input  logic [OFS_W-1:0] host_addr,
  input  logic [1:0]       host_be,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic             host_ready,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-2:0]    mem_addr,
  output logic [1:0]       mem_be,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  logic [2:0]    sync_q;
  logic          s_cs, s_rd, s_wr, active;
  logic [AW-1:0] map_addr, addr_q;
  logic [1:0]    be_q;
  logic [DW-1:0] wd_q, rd_q, rd_word;
  logic          we_q;
  hb_state_e     state;

  hb_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_cs, host_rd, host_wr}), .q(sync_q)
  );
  assign {s_cs, s_rd, s_wr} = sync_q;
  assign active = s_cs & (s_rd | s_wr);

  hb_addr_map #(.OFS_W(OFS_W)) u_map (
    .page4k(cfg_page4k), .bus16(cfg_bus16),
    .page(host_page), .ofs(host_addr), .byte_addr(map_addr)
  );

  hb_lanes #(.DW(DW)) u_lanes (
    .bus16(cfg_bus16), .lane_hi(addr_q[0]),
    .host_be(be_q), .host_wdata(wd_q),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (active) begin
          addr_q <= map_addr;
          be_q   <= host_be;
          wd_q   <= host_wdata;
          we_q   <= s_wr;
          state  <= ST_ACC;
        end
        ST_ACC:  state <= ST_LAT;
        ST_LAT: begin
          if (!we_q) rd_q <= rd_word;
          state <= ST_DONE;
        end
        default: if (!active) state <= ST_IDLE;
      endcase
    end
  end

  assign mem_en     = (state == ST_ACC);
  assign mem_we     = mem_en & we_q;
  assign mem_addr   = addr_q[AW-1:1];
  assign host_ready = (state == ST_DONE);
  assign host_rdata = rd_q;

  // R9
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !mem_en);

  // R8
  ready_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ready) |-> $past(mem_en, 2));

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && active) |=> host_ready);

  // R6
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !cfg_bus16) |-> ($countones(mem_be) == 1));

  // R3
  window_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && cfg_page4k) |-> (mem_addr[13:12] == 2'b00));

  // R10
  no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !s_cs) |=> !mem_en);
endmodule

// File: tb/paged_host_bridge_tb.sv
module paged_host_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_page4k = 1'b0, cfg_bus16 = 1'b1;
  logic        host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_page = '0;
  logic [13:0] host_addr = '0;
  logic [1:0]  host_be = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_ready, mem_en, mem_we;
  logic [14:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0, errors = 0, cycles = 0;
  int req_cnt = 0;
  logic [14:0] cap_addr;
  logic        cap_we;
  logic [1:0]  cap_be;
  logic [15:0] cap_wd;

  paged_host_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_page4k(cfg_page4k), .cfg_bus16(cfg_bus16),
    .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
    .host_page(host_page), .host_addr(host_addr), .host_be(host_be),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] pat(input logic [14:0] w);
    logic [31:0] p;
    p = {17'd0, w} * 32'h9E37;
    return p[15:0] ^ 16'h1234;
  endfunction

  always @(posedge clk) if (mem_en) mem_rdata <= pat(mem_addr);

  always @(negedge clk) if (mem_en) begin
    req_cnt = req_cnt + 1;
    cap_addr = mem_addr;
    cap_we = mem_we;
    cap_be = mem_be;
    cap_wd = mem_wdata;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] pg, input logic [13:0] ofs,
                        input logic [1:0] be, input logic [15:0] wd);
    logic [15:0] ba;
    logic [15:0] exp_rd, word_pat;
    int n;
    ba = cfg_page4k ? {pg[1], 2'b00, pg[0], ofs[11:0]} : {pg, ofs};
    if (cfg_bus16) ba[0] = 1'b0;
    @(negedge clk);
    req_cnt = 0;
    host_page = pg; host_addr = ofs; host_be = be; host_wdata = wd;
    host_cs = 1'b1; host_rd = !wr; host_wr = wr;
    n = 0;
    do begin @(negedge clk); n++; end while (!host_ready && n < 20);
    chk(n == 5, "R8 ready latency", n, 5);
    chk(req_cnt == 1, "R9 request count", req_cnt, 1);
    chk(cap_we == wr, "R9 write flag", {31'd0, cap_we}, {31'd0, wr});
    chk(cap_addr == ba[15:1], cfg_page4k ? "R3 window address" : "R2 page address",
        {17'd0, cap_addr}, {17'd0, ba[15:1]});
    word_pat = pat(ba[15:1]);
    if (wr) begin
      if (cfg_bus16) begin
        chk(cap_be == be && cap_wd == wd, "R4 word write lanes", {14'd0, cap_be, cap_wd}, {14'd0, be, wd});
      end else begin
        chk(cap_be == (ba[0] ? 2'b10 : 2'b01) && cap_wd == {wd[7:0], wd[7:0]}, "R6 byte write lanes",
            {14'd0, cap_be, cap_wd}, {14'd0, (ba[0] ? 2'b10 : 2'b01), wd[7:0], wd[7:0]});
      end
    end else begin
      if (cfg_bus16) begin
        exp_rd = word_pat;
        chk(host_rdata == exp_rd, "R5 word read", {16'd0, host_rdata}, {16'd0, exp_rd});
      end else begin
        exp_rd = {8'h00, ba[0] ? word_pat[15:8] : word_pat[7:0]};
        chk(host_rdata == exp_rd, "R7 byte read", {16'd0, host_rdata}, {16'd0, exp_rd});
      end
    end
    @(negedge clk);
    chk(host_ready == 1'b1, "R8 ready held", {31'd0, host_ready}, 32'd1);
    host_cs = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (host_ready && n < 20);
    chk(n == 3, "R8 release latency", n, 3);
    chk(req_cnt == 1, "R9 no extra request", req_cnt, 1);
  endtask

  initial begin
    logic [13:0] offs [6];
    offs[0] = 14'h0000; offs[1] = 14'h0001; offs[2] = 14'h0FFE;
    offs[3] = 14'h1003; offs[4] = 14'h2A55; offs[5] = 14'h3FFF;
    repeat (3) @(negedge clk);
    chk(!host_ready && !mem_en, "R1 reset outputs", {30'd0, host_ready, mem_en}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!host_ready && !mem_en, "R1 idle after reset", {30'd0, host_ready, mem_en}, 32'd0);

    for (int b = 1; b >= 0; b--) begin
      for (int p4 = 0; p4 < 2; p4++) begin
        cfg_bus16 = b[0]; cfg_page4k = p4[0];
        for (int pg = 0; pg < 4; pg++) begin
          for (int i = 0; i < 6; i++) begin
            for (int w = 0; w < 2; w++) begin
              access(w[0], pg[1:0], offs[i],
                     b[0] ? 2'((i + pg) % 3 + 1) : 2'b00,
                     16'hC3A5 ^ {pg[3:0], i[3:0], 8'h5A});
            end
          end
        end
      end
    end

    // R10: strobes without chip select
    req_cnt = 0;
    @(negedge clk);
    host_rd = 1'b1; host_wr = 1'b1;
    repeat (10) @(negedge clk);
    chk(req_cnt == 0, "R10 no request without cs", req_cnt, 0);
    chk(host_ready == 1'b0, "R10 ready stays low", {31'd0, host_ready}, 32'd0);
    host_rd = 1'b0; host_wr = 1'b0;
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule